// File: doc/BRIEF.md
# Dual-Mode Serial Memory Mode Controller

This block chooses the operating mode of a small serial memory that can stream its contents without a host or act as a slave on a two-wire bus. After reset the memory is in transmit-only mode: a separate transmit clock shifts stored bytes out. The first falling edge on the bus clock moves the block into a probation state of bidirectional mode. In that state, rising edges of the transmit clock are counted while the bus clock idles high. Each falling edge of the bus clock clears the count. If the count reaches the limit (128 by default), the block returns to transmit-only mode. On that return it pulses a request for one cycle, so the output shifter restarts at address zero, most significant bit first.

The block also watches the bus for START and STOP conditions. A START counts only if the bus was free. After it, the block captures the first byte and then the acknowledge bit. If the seven address bits match the memory's control code and the acknowledge is low, the block enters a locked state that stays in bidirectional mode until reset. In every bidirectional state the transmit clock keeps one job: its level gates write permission.

The mode state machine has three states. MD_TXONLY (transmit-only) moves to MD_PROBE on a bus-clock fall. MD_PROBE moves to MD_LOCKED on a lock pulse, or back to MD_TXONLY when the count hits the limit (the lock pulse wins if both happen). MD_LOCKED is left only by reset. The byte monitor has four states. MON_IDLE moves to MON_SHIFT on an accepted START. MON_SHIFT moves to MON_ACK after the eighth bus-clock rise. MON_ACK moves to MON_DONE on the ninth rise. A STOP returns any monitor state to MON_IDLE.

Top module: `dualmode_mode_ctrl`

## Requirements
- R1: While reset is held and just after it, bidir_mode_o, wr_qual_o and tx_restart_o are all low. After reset the bus counts as free (not busy).
- R2: In transmit-only mode, a high-to-low transition of bus_clk_i sets bidir_mode_o high. Nothing else leaves transmit-only mode.
- R3: wr_qual_o is high exactly when bidir_mode_o is high and txclk_i is high. It stays low in transmit-only mode whatever txclk_i does.
- R4: A rising edge of txclk_i is counted only in the probation state and only while bus_clk_i is high. Edges in transmit-only mode, in the locked state, or while bus_clk_i is held low change no mode.
- R5: Every falling edge of bus_clk_i clears the count. For example, 127 edges, then one bus-clock pulse, then 127 more edges leave the block in bidirectional mode.
- R6: In probation, the 128th counted edge (VCLK_LIMIT) makes tx_restart_o high for exactly one cycle, and bidir_mode_o then goes low. After 127 counted edges neither happens.
- R7: A START is bus_dat_i falling while bus_clk_i is high. A STOP is bus_dat_i rising while bus_clk_i is high. Changes of bus_dat_i while bus_clk_i is low are data bits and start no capture.
- R8: A START is accepted only while the bus is free. The bus becomes busy at an accepted START and free again at a STOP. A START seen while busy does not restart the capture.
- R9: After an accepted START, the block captures the first eight bits, most significant first. If the first seven bits are 1010000 and the ninth bit (the acknowledge) is low, the block locks. The eighth bit is a don't-care. Once locked, txclk_i edges never cause a reversion.
- R10: An address mismatch or a high acknowledge bit does not lock. The probation reversion still applies.
- R11: The locked state is cleared only by reset. After reset, probation and reversion work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Two-wire bus clock line, asynchronous |
| bus_dat_i | input | 1 | Two-wire bus data line, asynchronous |
| txclk_i | input | 1 | Transmit-only shift clock, asynchronous |
| bidir_mode_o | output | 1 | High in bidirectional mode (probation or locked) |
| wr_qual_o | output | 1 | Write permission: bidirectional mode and txclk_i high |
| tx_restart_o | output | 1 | One-cycle request to restart transmit-only output at address 0 |

## Verification
The bench builds the block with its defaults: VCLK_LIMIT of 128, SYNC_STAGES of 2, and the control code 1010000. Because the limit is only 128, each test can drive the exact edge counts 127 and 128, plus a full 128-edge window after a count clear, with nothing scaled down. This lets the reversion boundary and the effect of a bus-clock fall be checked at the true values. The two-stage synchronizers set a latency of a few cycles, which the bench absorbs by letting every line settle before it samples. The random trials pick a first byte and an acknowledge bit, often forcing the matching address, and follow them with 100 to 140 idle transmit-clock edges. This covers lock, no-lock and the reversion boundary in the same run.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    // Mode state machine
    typedef enum logic [1:0] {
        MD_TXONLY = 2'd0,
        MD_PROBE  = 2'd1,
        MD_LOCKED = 2'd2
    } mode_state_t;

    // Control byte monitor
    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_SHIFT = 2'd1,
        MON_ACK   = 2'd2,
        MON_DONE  = 2'd3
    } mon_state_t;

    // Indices of the synchronized lines
    localparam int LN_BCLK  = 0;
    localparam int LN_BDAT  = 1;
    localparam int LN_TXCLK = 2;
    localparam int N_LINES  = 3;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], raw_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;
    assign fall_o  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/bus_cond.sv
module bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_lvl_i,
    input  logic dat_rise_i,
    input  logic dat_fall_i,
    output logic start_ok_o,
    output logic stop_o
);
    logic busy;
    logic start_raw;

    assign start_raw  = dat_fall_i & clk_lvl_i;
    assign stop_o     = dat_rise_i & clk_lvl_i;
    assign start_ok_o = start_raw & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (stop_o) begin
            busy <= 1'b0;
        end else if (start_raw) begin
            busy <= 1'b1;
        end
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok_o |=> busy); // R8
    AST_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !busy); // R8

endmodule

// File: rtl/ctrl_byte_mon.sv
module ctrl_byte_mon
    import dmc_pkg::*;
#(
    parameter int              ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] CTRL_CODE = 7'b1010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok_i,
    input  logic stop_i,
    input  logic clk_rise_i,
    input  logic dat_lvl_i,
    output logic lock_o
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int NB_W   = $clog2(BYTE_W);

    mon_state_t        st;
    logic [BYTE_W-1:0] shreg;
    logic [NB_W-1:0]   nbits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= MON_IDLE;
            shreg <= '0;
            nbits <= '0;
        end else if (stop_i) begin
            st <= MON_IDLE;
        end else if (start_ok_i) begin
            st    <= MON_SHIFT;
            nbits <= '0;
        end else begin
            unique case (st)
                MON_IDLE: ;
                MON_SHIFT: begin
                    if (clk_rise_i) begin
                        shreg <= {shreg[BYTE_W-2:0], dat_lvl_i};
                        if (nbits == NB_W'(BYTE_W - 1)) begin
                            st <= MON_ACK;
                        end else begin
                            nbits <= nbits + 1'b1;
                        end
                    end
                end
                MON_ACK: begin
                    if (clk_rise_i) begin
                        st <= MON_DONE;
                    end
                end
                MON_DONE: ;
            endcase
        end
    end

    always_comb begin
        lock_o = (st == MON_ACK) && clk_rise_i && !dat_lvl_i
                 && (shreg[BYTE_W-1 -: ADDR_W] == CTRL_CODE)
                 && !stop_i && !start_ok_i;
    end

    AST_LOCK_ENDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> (st == MON_DONE)); // R9
    AST_CAPTURE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MON_IDLE && !start_ok_i) |=> (st == MON_IDLE)); // R8

endmodule

// File: rtl/edge_counter.sv
module edge_counter #(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic idle_i,
    input  logic inc_i,
    input  logic clr_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en_i || clr_i) begin
            cnt <= '0;
        end else if (inc_i && idle_i && (cnt != CW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit_o = (cnt == CW'(LIMIT));

    AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT)); // R6
    AST_CNT_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt == '0)); // R5

endmodule

// File: rtl/dualmode_mode_ctrl.sv
module dualmode_mode_ctrl
    import dmc_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         VCLK_LIMIT  = 128,
    parameter int         ADDR_W      = 7,
    parameter logic [6:0] CTRL_CODE   = 7'b1010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk_i,
    input  logic bus_dat_i,
    input  logic txclk_i,
    output logic bidir_mode_o,
    output logic wr_qual_o,
    output logic tx_restart_o
);
    // Idle values of the lines: bus lines rest high, transmit clock low
    localparam logic [N_LINES-1:0] IDLE_VALS = 3'b011;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] lvl;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] fall;

    assign raw = {txclk_i, bus_dat_i, bus_clk_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        line_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (IDLE_VALS[g])
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw[g]),
            .level_o (lvl[g]),
            .rise_o  (rise[g]),
            .fall_o  (fall[g])
        );
    end

    logic unused_txclk_fall;
    assign unused_txclk_fall = fall[LN_TXCLK];

    logic start_ok;
    logic stop;
    logic lock;
    logic hit;

    bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_lvl_i  (lvl[LN_BCLK]),
        .dat_rise_i (rise[LN_BDAT]),
        .dat_fall_i (fall[LN_BDAT]),
        .start_ok_o (start_ok),
        .stop_o     (stop)
    );

    ctrl_byte_mon #(
        .ADDR_W    (ADDR_W),
        .CTRL_CODE (CTRL_CODE[ADDR_W-1:0])
    ) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok_i (start_ok),
        .stop_i     (stop),
        .clk_rise_i (rise[LN_BCLK]),
        .dat_lvl_i  (lvl[LN_BDAT]),
        .lock_o     (lock)
    );

    mode_state_t st, st_nx;

    edge_counter #(
        .LIMIT (VCLK_LIMIT)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st == MD_PROBE),
        .idle_i (lvl[LN_BCLK]),
        .inc_i  (rise[LN_TXCLK]),
        .clr_i  (fall[LN_BCLK]),
        .hit_o  (hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= MD_TXONLY;
        end else begin
            st <= st_nx;
        end
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            MD_TXONLY: if (fall[LN_BCLK]) st_nx = MD_PROBE;
            MD_PROBE: begin
                if (lock) begin
                    st_nx = MD_LOCKED;
                end else if (hit) begin
                    st_nx = MD_TXONLY;
                end
            end
            MD_LOCKED: st_nx = MD_LOCKED;
            default:   st_nx = MD_TXONLY;
        endcase
    end

    // Outputs
    always_comb begin
        bidir_mode_o = (st != MD_TXONLY);
        wr_qual_o    = (st != MD_TXONLY) && lvl[LN_TXCLK];
        tx_restart_o = (st == MD_PROBE) && hit && !lock;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MD_LOCKED) |=> (st == MD_LOCKED)); // R11
    AST_WRQ_NEEDS_BIDIR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_qual_o |-> bidir_mode_o); // R3
    AST_RESTART_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_restart_o |=> (!bidir_mode_o && !tx_restart_o)); // R6
    AST_TXONLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MD_TXONLY && !fall[LN_BCLK]) |=> (st == MD_TXONLY)); // R2

endmodule

// File: tb/sim_dualmode_mode_ctrl.sv
`timescale 1ns/1ps
module sim_dualmode_mode_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b1;
    logic bdat = 1'b1;
    logic txclk = 1'b0;
    logic bidir, wrq, rstrt;

    int checks = 0;
    int errs   = 0;
    int rcount = 0;
    int run    = 0;
    int maxrun = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dualmode_mode_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_clk_i    (bclk),
        .bus_dat_i    (bdat),
        .txclk_i      (txclk),
        .bidir_mode_o (bidir),
        .wr_qual_o    (wrq),
        .tx_restart_o (rstrt)
    );

    always @(negedge clk) begin
        if (rstrt === 1'b1) begin
            rcount++;
            run++;
            if (run > maxrun) maxrun = run;
        end else begin
            run = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bclk = 1'b1; bdat = 1'b1; txclk = 1'b0;
        wt(4);
        rst_n = 1'b1;
        wt(4);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            txclk = 1'b1; wt(3);
            txclk = 1'b0; wt(3);
        end
        wt(8);
    endtask

    task automatic bclk_pulse();
        bclk = 1'b0; wt(6);
        bclk = 1'b1; wt(6);
    endtask

    task automatic send_start();
        bdat = 1'b0; wt(6);
        bclk = 1'b0; wt(6);
    endtask

    task automatic send_bit(input logic b);
        bdat = b;    wt(4);
        bclk = 1'b1; wt(8);
        bclk = 1'b0; wt(4);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(ack);
    endtask

    task automatic send_stop();
        bdat = 1'b0; wt(4);
        bclk = 1'b1; wt(6);
        bdat = 1'b1; wt(6);
    endtask

    function automatic int exp_lock(input logic [7:0] b, input logic ack);
        return ((b[7:1] == 7'b1010000) && (ack == 1'b0)) ? 1 : 0;
    endfunction

    function automatic int exp_mode(input int lk, input int n);
        return (lk != 0 || n < 128) ? 1 : 0;
    endfunction

    initial begin
        #950000;
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int r0;
        int seed;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0;
        wt(2);
        chk("R1 mode in reset", bidir, 0);
        chk("R1 restart in reset", rstrt, 0);
        do_reset();
        chk("R1 mode after reset", bidir, 0);
        chk("R1 wr after reset", wrq, 0);

        // R3/R4: transmit clock in transmit-only mode
        txclk = 1'b1; wt(6);
        chk("R3 wr low in tx-only", wrq, 0);
        txclk = 1'b0; wt(6);
        r0 = rcount;
        pulses(200);
        chk("R4 tx-only ignores txclk", bidir, 0);
        chk("R4 no restart in tx-only", rcount - r0, 0);

        // R2 entry
        bclk_pulse();
        chk("R2 bus clock fall enters bidir", bidir, 1);
        txclk = 1'b1; wt(6);
        chk("R3 wr high in bidir", wrq, 1);
        txclk = 1'b0; wt(6);
        chk("R3 wr low with txclk low", wrq, 0);
        bclk_pulse();

        // R6 / R5 boundary
        r0 = rcount;
        pulses(127);
        chk("R6 no revert at 127", bidir, 1);
        bclk_pulse();
        pulses(127);
        chk("R5 fall clears count", bidir, 1);
        chk("R5 no restart", rcount - r0, 0);
        maxrun = 0;
        pulses(1);
        chk("R6 revert at 128", bidir, 0);
        chk("R6 one restart", rcount - r0, 1);
        chk("R6 restart width", maxrun, 1);

        // R4 bus clock held low
        do_reset();
        bclk = 1'b0; wt(6);
        r0 = rcount;
        pulses(200);
        chk("R4 not counted with bus clock low", bidir, 1);
        bclk = 1'b1; wt(6);
        pulses(128);
        chk("R6 revert after release", bidir, 0);
        chk("R6 restart after release", rcount - r0, 1);

        // R7 byte without START
        do_reset();
        bclk = 1'b0; wt(6);
        send_byte(8'hA0, 1'b0);
        bdat = 1'b1; wt(4); bclk = 1'b1; wt(6);
        pulses(128);
        chk("R7 no capture without START", bidir, 0);

        // R8 START while busy ignored
        do_reset();
        send_start();
        send_bit(1'b1); send_bit(1'b1);
        bdat = 1'b1; wt(4); bclk = 1'b1; wt(6); bdat = 1'b0; wt(6); bclk = 1'b0; wt(6);
        send_byte(8'hA0, 1'b0);
        send_stop();
        pulses(128);
        chk("R8 busy START ignored", bidir, 0);
        send_start();
        send_byte(8'hA0, 1'b0);
        send_stop();
        r0 = rcount;
        pulses(300);
        chk("R9 locked after STOP then START", bidir, 1);
        chk("R9 no restart when locked", rcount - r0, 0);
        bclk_pulse();
        txclk = 1'b1; wt(6);
        chk("R3 wr high when locked", wrq, 1);
        txclk = 1'b0; wt(6);

        // R11
        do_reset();
        chk("R11 reset clears lock", bidir, 0);
        bclk_pulse();
        pulses(128);
        chk("R11 reversion works after reset", bidir, 0);

        // R10 / R9 direction bit
        do_reset();
        send_start(); send_byte(8'hA0, 1'b1); send_stop();
        pulses(128);
        chk("R10 nack no lock", bidir, 0);
        do_reset();
        send_start(); send_byte(8'hA2, 1'b0); send_stop();
        pulses(128);
        chk("R10 wrong address no lock", bidir, 0);
        do_reset();
        send_start(); send_byte(8'hA1, 1'b0); send_stop();
        pulses(128);
        chk("R9 direction bit ignored", bidir, 1);

        // Random trials
        for (int t = 0; t < 16; t++) begin
            logic [7:0] b;
            logic       ack;
            int         n;
            int         lk;
            b   = 8'($urandom);
            if ($urandom % 2 == 0) b[7:1] = 7'b1010000;
            ack = 1'($urandom % 2);
            n   = 100 + int'($urandom % 41);
            lk  = exp_lock(b, ack);
            do_reset();
            send_start(); send_byte(b, ack); send_stop();
            r0 = rcount;
            pulses(n);
            chk(lk != 0 ? "R9 random lock" : "R10 random no-lock", bidir, exp_mode(lk, n));
            chk("R6 random restart count", rcount - r0, 1 - exp_mode(lk, n));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule